// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller with Change Return

This block is a clocked controller for a machine that sells one item at a price of 25 cents. Coin acceptors upstream give it single-cycle pulses for a nickel, a dime or a quarter, with at most one coin per clock. The controller keeps a running credit in steps of 5 cents. It holds that credit while no coin arrives.

When a coin brings the credit to 25 cents or more, the controller enters a settlement state for exactly one cycle. In that cycle it asserts the dispense strobe and drives the change outputs that refund the overpayment, then it drops back to zero credit. An overpayment is never more than 20 cents, because the largest credit held before a coin is 20 cents. Each refund amount maps to a fixed coin combination on the change outputs.

The state is one flop per credit level, one-hot. All outputs come from the registered state only.

Top module: `vend_ctrl`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets the credit to 0 cents. While the credit is 0, all four outputs are low. A reset also cancels a settlement state that is in progress.
- R2: On each clock edge with the credit below 25 cents, exactly one coin input high adds its value to the credit: coin_nickel adds 5 cents, coin_dime adds 10 and coin_quarter adds 25.
- R3: With the credit below 25 cents and no coin input high, the credit stays the same on the next edge.
- R4: A credit of 25 to 45 cents is a settlement state. It asserts dispense for exactly one cycle, and the next edge returns the credit to 0 cents whatever the coin inputs are. Coins that arrive during a settlement cycle are lost.
- R5: The change outputs follow the settled credit. At 25 cents none is high. At 30 cents ret_nickel is high. At 35 cents ret_dime is high. At 40 cents both ret_dime and ret_nickel are high. At 45 cents ret_two_dimes is high. A change output is only ever high together with dispense.
- R6: The credit is held in a ten-bit one-hot register. Bit k is set when the credit is 5·k cents, for k = 0 to 9.
- R7: The outputs depend only on the registered state. A change on a coin input alters no output before the next rising edge.
- R8: If two or three coin inputs are high on the same edge while the credit is below 25 cents, the coins are ignored and the credit is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| coin_nickel | input | 1 | Single-cycle pulse for a 5-cent coin |
| coin_dime | input | 1 | Single-cycle pulse for a 10-cent coin |
| coin_quarter | input | 1 | Single-cycle pulse for a 25-cent coin |
| dispense | output | 1 | High for one cycle to release the item |
| ret_nickel | output | 1 | Return a 5-cent coin (this cycle) |
| ret_dime | output | 1 | Return a 10-cent coin (this cycle) |
| ret_two_dimes | output | 1 | Return two 10-cent coins (this cycle) |

## Verification
Two functions can fall in the same cycle: settlement with its return to zero credit, and the arrival of a new coin. The bench drives a quarter in the cycle straight after a settlement. It then shows that the coin was lost by the next purchase, which is judged on its exact change pattern. The same kind of later purchase shows that an illegal multi-coin cycle and a reset during a settlement each left the credit where the requirements say.

// File: rtl/vend_pkg.sv
package vend_pkg;
  // credit is counted in units of the smallest coin
  localparam int STEP_CENTS    = 5;
  localparam int NICKEL_UNITS  = 1;
  localparam int DIME_UNITS    = 2;
  localparam int QUARTER_UNITS = 5;
  localparam int PRICE_UNITS   = 5;
  // highest credit = price - 1 + largest coin
  localparam int NUM_STATES    = PRICE_UNITS + QUARTER_UNITS;
  localparam int UNIT_W        = $clog2(NUM_STATES);

  typedef logic [UNIT_W-1:0]     units_t;
  typedef logic [NUM_STATES-1:0] onehot_t;

  typedef struct packed {
    logic quarter;
    logic dime;
    logic nickel;
  } coins_t;

  // change pattern {two_dimes, dime, nickel}
  typedef struct packed {
    logic two_dimes;
    logic dime;
    logic nickel;
  } change_t;

  function automatic units_t coin_value(coins_t c);
    units_t v;
    v = '0;
    if (c.nickel)  v = units_t'(NICKEL_UNITS);
    if (c.dime)    v = units_t'(DIME_UNITS);
    if (c.quarter) v = units_t'(QUARTER_UNITS);
    return v;
  endfunction

  function automatic units_t onehot_index(onehot_t s);
    units_t idx;
    idx = '0;
    for (int i = 0; i < NUM_STATES; i++)
      if (s[i]) idx = units_t'(i);
    return idx;
  endfunction

  function automatic logic at_price(units_t u);
    return u >= units_t'(PRICE_UNITS);
  endfunction

  // overpayment in units -> coins handed back
  function automatic change_t change_for(int over_units);
    change_t c;
    c = '0;
    case (over_units)
      1:       c.nickel    = 1'b1;
      2:       c.dime      = 1'b1;
      3: begin c.dime      = 1'b1; c.nickel = 1'b1; end
      4:       c.two_dimes = 1'b1;
      default: c = '0;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/vend_coin_decode.sv
module vend_coin_decode
  import vend_pkg::*;
(
  input  coins_t coins,
  output units_t add_units,
  output logic   multi_coin
);
  logic [1:0] coin_count;

  assign coin_count = 2'($countones(coins));
  assign multi_coin = coin_count > 2'd1;
  assign add_units  = multi_coin ? '0 : coin_value(coins);

  // R2: a decoded value is always one legal coin or nothing
  always_comb begin
    p_legal_value_r2: assert (add_units == '0 ||
                              add_units == units_t'(NICKEL_UNITS) ||
                              add_units == units_t'(DIME_UNITS) ||
                              add_units == units_t'(QUARTER_UNITS))
      else $error("illegal decoded coin value");
  end
endmodule

// File: rtl/vend_state.sv
module vend_state
  import vend_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  units_t  add_units,
  input  logic    multi_coin,
  output onehot_t state_q,
  output units_t  credit
);
  onehot_t state_d;
  units_t  next_credit;
  logic    settling;

  assign credit   = onehot_index(state_q);
  assign settling = at_price(credit);

  always_comb begin
    if (settling)        next_credit = '0;
    else if (multi_coin) next_credit = credit;
    else                 next_credit = units_t'(credit + add_units);
  end

  for (genvar k = 0; k < NUM_STATES; k++) begin : g_bit
    assign state_d[k] = (next_credit == units_t'(k));
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= onehot_t'(1);
    else     state_q <= state_d;
  end

  p_reset_zero_r1: assert property (@(posedge clk)
    rst |=> state_q == onehot_t'(1));

  p_accumulate_r2: assert property (@(posedge clk) disable iff (rst)
    (!settling && !multi_coin) |=>
      credit == units_t'($past(credit) + $past(add_units)));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!settling && add_units == '0) |=> $stable(state_q));

  p_settle_clears_r4: assert property (@(posedge clk) disable iff (rst)
    settling |=> credit == '0);

  p_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    $countones(state_q) == 1);

  p_multi_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!settling && multi_coin) |=> $stable(state_q));
endmodule

// File: rtl/vend_outputs.sv
module vend_outputs
  import vend_pkg::*;
(
  input  onehot_t state_q,
  output logic    dispense,
  output logic    ret_nickel,
  output logic    ret_dime,
  output logic    ret_two_dimes
);
  change_t chg;

  always_comb begin
    dispense = 1'b0;
    chg      = '0;
    for (int k = PRICE_UNITS; k < NUM_STATES; k++) begin
      if (state_q[k]) begin
        dispense = 1'b1;
        chg      = chg | change_for(k - PRICE_UNITS);
      end
    end
  end

  assign ret_nickel    = chg.nickel;
  assign ret_dime      = chg.dime;
  assign ret_two_dimes = chg.two_dimes;

  // R5: change is handed back only together with an item
  always_comb begin
    p_change_with_item_r5: assert (!(ret_nickel || ret_dime || ret_two_dimes) || dispense)
      else $error("change without dispense");
  end
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
  import vend_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic coin_nickel,
  input  logic coin_dime,
  input  logic coin_quarter,
  output logic dispense,
  output logic ret_nickel,
  output logic ret_dime,
  output logic ret_two_dimes
);
  coins_t  coins;
  units_t  add_units;
  logic    multi_coin;
  onehot_t state_q;
  units_t  credit;

  assign coins = '{quarter: coin_quarter, dime: coin_dime, nickel: coin_nickel};

  vend_coin_decode u_decode (
    .coins      (coins),
    .add_units  (add_units),
    .multi_coin (multi_coin)
  );

  vend_state u_state (
    .clk        (clk),
    .rst        (rst),
    .add_units  (add_units),
    .multi_coin (multi_coin),
    .state_q    (state_q),
    .credit     (credit)
  );

  vend_outputs u_out (
    .state_q       (state_q),
    .dispense      (dispense),
    .ret_nickel    (ret_nickel),
    .ret_dime      (ret_dime),
    .ret_two_dimes (ret_two_dimes)
  );

  p_single_dispense_r4: assert property (@(posedge clk) disable iff (rst)
    dispense |=> !dispense);

  p_moore_stable_r7: assert property (@(posedge clk) disable iff (rst)
    $stable(state_q) |-> $stable({dispense, ret_nickel, ret_dime, ret_two_dimes}));
endmodule

// File: tb/tb_vend_ctrl.sv
`timescale 1ns/1ps
module tb_vend_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic coin_nickel = 1'b0, coin_dime = 1'b0, coin_quarter = 1'b0;
  logic dispense, ret_nickel, ret_dime, ret_two_dimes;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  vend_ctrl dut (
    .clk(clk), .rst(rst),
    .coin_nickel(coin_nickel), .coin_dime(coin_dime), .coin_quarter(coin_quarter),
    .dispense(dispense), .ret_nickel(ret_nickel), .ret_dime(ret_dime),
    .ret_two_dimes(ret_two_dimes)
  );

  // {quarter,dime,nickel, dispense,ret_nickel,ret_dime,ret_two_dimes}
  localparam int NV = 35;
  localparam logic [6:0] VEC [NV] = '{
    7'b001_0000, // 5
    7'b001_0000, // 10
    7'b010_0000, // 20
    7'b010_1100, // 30: nickel back
    7'b000_0000, // 0
    7'b100_1000, // 25 exact
    7'b100_0000, // coin during settle lost -> 0
    7'b010_0000, // 10
    7'b100_1010, // 35: dime back
    7'b000_0000,
    7'b010_0000, // 10
    7'b010_0000, // 20
    7'b100_1001, // 45: two dimes
    7'b000_0000,
    7'b001_0000, // 5
    7'b010_0000, // 15
    7'b100_1110, // 40: dime + nickel
    7'b000_0000,
    7'b011_0000, // illegal, hold 0
    7'b100_1000, // 25 proves hold at 0
    7'b000_0000,
    7'b010_0000, // 10
    7'b000_0000, // idle hold 10
    7'b001_0000, // 15
    7'b010_1000, // 25
    7'b000_0000,
    7'b001_0000, // 5
    7'b111_0000, // illegal, hold 5
    7'b100_1100, // 30 proves hold at 5
    7'b000_0000,
    7'b010_0000, // 10
    7'b110_0000, // illegal, hold 10
    7'b010_0000, // 20
    7'b001_1000, // 25
    7'b000_0000
  };

  task automatic check(input logic [3:0] exp, input string tag);
    logic [3:0] act;
    act = {dispense, ret_nickel, ret_dime, ret_two_dimes};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: outputs %b expected %b", tag, act, exp);
    end
  endtask

  // called at a falling edge: drive coins, let one rising edge pass, check
  task automatic step(input logic [2:0] c, input logic [3:0] exp, input string tag);
    {coin_quarter, coin_dime, coin_nickel} = c;
    @(negedge clk);
    {coin_quarter, coin_dime, coin_nickel} = 3'b000;
    check(exp, tag);
  endtask

  initial begin
    #(8 * 5000);
    errors++;
    $display("FAIL watchdog: run did not end, outputs %b expected completion",
             {dispense, ret_nickel, ret_dime, ret_two_dimes});
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(4'b0000, "R1 reset state");

    // vector walk: R2 R3 R4 R5 R6 R8
    for (int i = 0; i < NV; i++)
      step(VEC[i][6:4], VEC[i][3:0], $sformatf("R2/R3/R4/R5/R6/R8 vector %0d", i));

    // R1: reset in the middle of a credit discards it
    step(3'b010, 4'b0000, "R2 pre-reset 10");
    step(3'b010, 4'b0000, "R2 pre-reset 20");
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(4'b0000, "R1 reset after 20");
    step(3'b100, 4'b1000, "R1 credit cleared, quarter gives 25");
    step(3'b000, 4'b0000, "R4 back to zero");

    // R7: outputs do not react to inputs between edges
    step(3'b001, 4'b0000, "R2 5");
    step(3'b001, 4'b0000, "R2 10");
    step(3'b010, 4'b0000, "R2 20");
    coin_quarter = 1'b1;
    #1;
    check(4'b0000, "R7 no output before edge");
    @(negedge clk);
    coin_quarter = 1'b0;
    check(4'b1001, "R5 45 two dimes");
    step(3'b000, 4'b0000, "R4 back to zero");

    // R1: reset during a settlement cycle wins over coins
    step(3'b100, 4'b1000, "R4 settle 25");
    rst = 1'b1; coin_quarter = 1'b1;
    @(negedge clk);
    rst = 1'b0; coin_quarter = 1'b0;
    check(4'b0000, "R1 reset during settle");
    step(3'b010, 4'b0000, "R1 after reset 10");
    step(3'b100, 4'b1010, "R1 credit from zero, 35");
    step(3'b000, 4'b0000, "R4 back to zero");

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule